// File: doc/BRIEF.md
# Port C Change-of-State Interrupt Controller

This block watches two pins of port C, bit 3 and bit 7, in each of several I/O groups and raises an interrupt request when a qualifying transition appears on them. The value watched is the pin level itself. A transition counts whether an outside source drives the pin or the block's own port-C output latch drives it, so software can raise an interrupt by writing the port. Each group has its own mode setting. In one mode the group is silent. In another, a rising edge on bit 3 fires. In the third, bit 3 and an active-low bit 7 both take part.

Each group's request is sent to one of six interrupt request lines, or to none. When several groups share a line, their requests are ORed. Each line carries a pulse whose minimum width is set at run time. Before detection, the watched pins pass through a two-flop synchronizer. The hardware sets no priority between groups or between bits: after a pulse, software reads bits 3 and 7 of each group to find the source. Re-arming follows from the edge rule: bit 3 must fall back low, and bit 7 must go back high, before the next edge on that bit can count.

Top module: `portc_cos_irq`

## Requirements
- R1: While `rst` is high, and in the cycles after it falls with the pins held steady and low, every bit of `irq_out` is 0.
- R2: A group whose mode is 1 (edge mode) fires on a 0-to-1 change of its bit 3 (`pc_watch[g][0]`). The new level must be stable before some rising clock edge E0. The routed line is then high from clock edge E0+3 onward.
- R3: In edge mode the group ignores every change of bit 7 (`pc_watch[g][1]`) and every falling edge of bit 3.
- R4: Once bit 3 has fired, holding it high gives no further pulse. Bit 3 must return to 0 before a later 0-to-1 change can fire again.
- R5: A group in mode 2 (programmable) fires on a 0-to-1 change of bit 3 only when bit 7 is 0 after the change. When bit 7 is 1, that change is ignored.
- R6: In programmable mode, a 1-to-0 change of bit 7 fires only when bit 3 is 0 after the change. A rising edge of bit 7 never fires.
- R7: A group in mode 0 or mode 3 produces no pulse for any pin change.
- R8: A group's route value k (0 to 5) sends its requests to `irq_out[k]` only. Route values 6 and 7 send them to no line.
- R9: When two groups route to the same line, the line is the OR of their pulses.
- R10: Each pulse lasts `pulse_len` cycles, and a value of 0 counts as 1. A new request on a line that is already pulsing restarts the full width from that request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_watch | input | 2x2 | Per group: bit 0 is the port C bit 3 pin level, bit 1 is the port C bit 7 pin level |
| grp_mode | input | 2x2 | Per group mode: 0 off, 1 edge, 2 programmable, 3 off |
| grp_route | input | 2x3 | Per group line select: 0 to 5 picks a line, 6 and 7 pick none |
| pulse_len | input | 4 | Minimum pulse width in cycles (0 counts as 1) |
| irq_out | output | 6 | Interrupt request lines |

## Verification
The embedded properties run on every cycle. They check that a detected event only ever comes from an enabled mode, and that an edge-mode event always follows a low level on bit 3. They also check that a programmable-mode event always comes with bit 7 low, that each routed event raises its chosen line on the next cycle, and that a line can only rise after a request and holds for wider settings. Only the bench scenarios can show the exact three-cycle latency, the exact pulse widths including the zero-width case, the restart of a pulse on a retrigger, the OR of two groups on one line, and the silence of unrouted and disabled groups. To show these, the bench sweeps every mode against every old and new pair of watched pin levels.

// File: rtl/cos_irq_pkg.sv
package cos_irq_pkg;

    typedef enum logic [1:0] {
        CM_OFF  = 2'd0,
        CM_EDGE = 2'd1,
        CM_PROG = 2'd2,
        CM_RSVD = 2'd3
    } cos_mode_e;

    // Watched pin pair of one group: b7 is port C bit 7, b3 is port C bit 3
    typedef struct packed {
        logic b7;
        logic b3;
    } watch_t;

    localparam int unsigned DEF_GROUPS = 2;
    localparam int unsigned DEF_LINES  = 6;
    localparam int unsigned DEF_LEN_W  = 4;
    localparam int unsigned SYNC_DEPTH = 2;

    function automatic int unsigned route_width(int unsigned lines);
        return $clog2(lines + 1);
    endfunction

    // Qualify a transition from prv to cur under mode m
    function automatic logic cos_event(cos_mode_e m, watch_t cur, watch_t prv);
        logic lo_rise;
        logic hi_fall;
        logic res;
        lo_rise = cur.b3 & ~prv.b3;
        hi_fall = ~cur.b7 & prv.b7;
        case (m)
            CM_EDGE: res = lo_rise;
            CM_PROG: res = (lo_rise & ~cur.b7) | (hi_fall & ~cur.b3);
            default: res = 1'b0;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/cos_sync.sv
module cos_sync #(
    parameter int unsigned WIDTH = 2,
    parameter int unsigned DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [DEPTH-1:0][WIDTH-1:0] stage;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage <= '0;
        end else begin
            stage[0] <= d;
            for (int i = 1; i < DEPTH; i++) begin
                stage[i] <= stage[i-1];
            end
        end
    end

    assign q = stage[DEPTH-1];
endmodule

// File: rtl/cos_detect.sv
module cos_detect
    import cos_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] pins,
    input  logic [1:0] mode,
    output logic       evt
);
    watch_t    cur;
    watch_t    prv;
    cos_mode_e mode_e;
    logic [1:0] synced;

    cos_sync #(.WIDTH(2), .DEPTH(SYNC_DEPTH)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pins),
        .q   (synced)
    );

    assign cur    = watch_t'(synced);
    assign mode_e = cos_mode_e'(mode);

    always_ff @(posedge clk) begin
        if (rst) begin
            prv <= '0;
            evt <= 1'b0;
        end else begin
            prv <= cur;
            evt <= cos_event(mode_e, cur, prv);
        end
    end

    p_off_silent_r7: assert property (@(posedge clk) disable iff (rst)
        evt |-> ($past(mode_e) == CM_EDGE || $past(mode_e) == CM_PROG));

    p_rearm_low_r4: assert property (@(posedge clk) disable iff (rst)
        (evt && $past(mode_e) == CM_EDGE) |-> (!$past(prv.b3) && $past(cur.b3)));

    p_prog_b7_low_r6: assert property (@(posedge clk) disable iff (rst)
        (evt && $past(mode_e) == CM_PROG) |-> !$past(cur.b7));
endmodule

// File: rtl/cos_stretch.sv
module cos_stretch #(
    parameter int unsigned LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig,
    input  logic [LEN_W-1:0] len,
    output logic             pulse
);
    logic [LEN_W-1:0] cnt;
    logic [LEN_W-1:0] len_eff;

    assign len_eff = (len == '0) ? LEN_W'(1) : len;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (trig) begin
            cnt <= len_eff;
        end else if (cnt != '0) begin
            cnt <= cnt - LEN_W'(1);
        end
    end

    assign pulse = (cnt != '0);

    p_rise_src_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse) |-> $past(trig));

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        ($rose(pulse) && $past(len_eff) > LEN_W'(1)) |=> pulse);
endmodule

// File: rtl/portc_cos_irq.sv
module portc_cos_irq
    import cos_irq_pkg::*;
#(
    parameter int unsigned N_GROUPS = DEF_GROUPS,
    parameter int unsigned N_LINES  = DEF_LINES,
    parameter int unsigned LEN_W    = DEF_LEN_W,
    parameter int unsigned SEL_W    = route_width(DEF_LINES)
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [N_GROUPS-1:0][1:0]         pc_watch,
    input  logic [N_GROUPS-1:0][1:0]         grp_mode,
    input  logic [N_GROUPS-1:0][SEL_W-1:0]   grp_route,
    input  logic [LEN_W-1:0]                 pulse_len,
    output logic [N_LINES-1:0]               irq_out
);
    logic [N_GROUPS-1:0] grp_evt;
    logic [N_LINES-1:0]  line_trig;

    for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
        cos_detect u_det (
            .clk  (clk),
            .rst  (rst),
            .pins (pc_watch[g]),
            .mode (grp_mode[g]),
            .evt  (grp_evt[g])
        );
    end

    always_comb begin
        line_trig = '0;
        for (int j = 0; j < N_LINES; j++) begin
            for (int g = 0; g < N_GROUPS; g++) begin
                if (grp_evt[g] && grp_route[g] == SEL_W'(j)) begin
                    line_trig[j] = 1'b1;
                end
            end
        end
    end

    for (genvar j = 0; j < N_LINES; j++) begin : g_line
        cos_stretch #(.LEN_W(LEN_W)) u_str (
            .clk   (clk),
            .rst   (rst),
            .trig  (line_trig[j]),
            .len   (pulse_len),
            .pulse (irq_out[j])
        );

        for (genvar g = 0; g < N_GROUPS; g++) begin : g_chk
            p_route_r8: assert property (@(posedge clk) disable iff (rst)
                (grp_evt[g] && grp_route[g] == SEL_W'(j)) |=> irq_out[j]);
        end
    end
endmodule

// File: tb/portc_cos_irq_test.sv
module portc_cos_irq_test;
    localparam int NG  = 2;
    localparam int NL  = 6;
    localparam int LW  = 4;
    localparam int SW  = 3;
    localparam int WIN = 24;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic                   rst;
    logic [NG-1:0][1:0]     pins;
    logic [NG-1:0][1:0]     mode;
    logic [NG-1:0][SW-1:0]  route;
    logic [LW-1:0]          plen;
    logic [NL-1:0]          irq;

    int checks = 0;
    int fails  = 0;

    portc_cos_irq uut (
        .clk       (clk),
        .rst       (rst),
        .pc_watch  (pins),
        .grp_mode  (mode),
        .grp_route (route),
        .pulse_len (plen),
        .irq_out   (irq)
    );

    task automatic check_vec(input string tag, input logic [NL-1:0] act, input logic [NL-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // Called at a negedge. Applies p_a now, p_b after sample t_b-1 (t_b<0: never).
    // Expected events: (t0,l0) and (t1,l1), line NL means none.
    task automatic run_window(input logic [NG-1:0][1:0] p_a, input int t_b,
                              input logic [NG-1:0][1:0] p_b,
                              input int t0, input int l0, input int t1, input int l1,
                              input int w, input string tag);
        logic [NL-1:0] exp;
        logic          bad;
        int            bad_i;
        logic [NL-1:0] bad_a;
        logic [NL-1:0] bad_e;
        bad = 1'b0; bad_i = 0; bad_a = '0; bad_e = '0;
        pins = p_a;
        for (int i = 0; i < WIN; i++) begin
            @(posedge clk);
            @(negedge clk);
            exp = '0;
            if (l0 < NL && i >= t0 && i < t0 + w) exp[l0] = 1'b1;
            if (l1 < NL && i >= t1 && i < t1 + w) exp[l1] = 1'b1;
            if (!bad && irq !== exp) begin
                bad = 1'b1; bad_i = i; bad_a = irq; bad_e = exp;
            end
            if (i + 1 == t_b) pins = p_b;
        end
        checks++;
        if (bad) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual %b expected %b", tag, bad_i, bad_a, bad_e);
        end
    endtask

    function automatic logic exp_fire(input int m, input logic [1:0] f, input logic [1:0] t);
        logic r3, f7;
        r3 = !f[0] && t[0];
        f7 = f[1] && !t[1];
        if (m == 1) return r3;
        if (m == 2) return (r3 && !t[1]) || (f7 && !t[0]);
        return 1'b0;
    endfunction

    // Quietly set both groups' pins with modes off, then let them settle
    task automatic settle(input logic [NG-1:0][1:0] p);
        @(negedge clk);
        mode = '0;
        pins = p;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [NG-1:0][1:0] pa;
        logic [NG-1:0][1:0] pb;
        int n;
        int w;
        rst = 1'b1; pins = '0; mode = '0; route = '0; plen = 4'd2;

        // R1: reset state
        repeat (3) @(negedge clk);
        check_vec("R1 during reset", irq, '0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check_vec("R1 after reset", irq, '0);

        // R2..R7, R8, R10: sweep of mode x old pins x new pins per group
        n = 0;
        for (int g = 0; g < NG; g++) begin
            for (int m = 0; m < 4; m++) begin
                for (int f = 0; f < 4; f++) begin
                    for (int t = 0; t < 4; t++) begin
                        logic fire;
                        int rte;
                        string tag;
                        pa = '0;
                        pa[g] = 2'(f);
                        settle(pa);
                        rte = n % 8;
                        plen = 4'((n * 5) % 16);
                        route[g] = SW'(rte);
                        route[1-g] = SW'((rte + 1) % 8);
                        mode[g] = 2'(m);
                        @(negedge clk);
                        fire = exp_fire(m, 2'(f), 2'(t));
                        w = (plen == 0) ? 1 : int'(plen);
                        pb = pa;
                        pb[g] = 2'(t);
                        $sformat(tag, "R2/R3/R5/R6/R7/R8/R10 sweep g%0d mode%0d %0d->%0d route%0d len%0d",
                                 g, m, f, t, rte, plen);
                        run_window(pb, -1, pb, 3, (fire && rte < NL) ? rte : NL, 0, NL, w, tag);
                        n++;
                    end
                end
            end
        end

        // R4: re-arm in edge mode
        settle('0);
        route[0] = 3'd1; plen = 4'd2; mode[0] = 2'd1;
        @(negedge clk);
        pa = '0; pa[0] = 2'b01;
        pb = '0; pb[0] = 2'b11;
        run_window(pa, 6, pb, 3, 1, 0, NL, 2, "R4 first rise then bit7 rise");
        run_window(pb, -1, pb, 0, NL, 0, NL, 1, "R4 bit3 held high no repeat");
        pa = '0; pa[0] = 2'b10;
        run_window(pa, -1, pa, 0, NL, 0, NL, 1, "R4 bit3 fall silent");
        pb = '0; pb[0] = 2'b11;
        run_window(pb, -1, pb, 3, 1, 0, NL, 2, "R4 re-armed rise fires");

        // R9: two groups share a line, overlapping pulses (also R10 restart)
        settle('0);
        route[0] = 3'd2; route[1] = 3'd2; plen = 4'd3;
        mode[0] = 2'd1; mode[1] = 2'd1;
        @(negedge clk);
        pa = '0; pa[0] = 2'b01;
        pb = pa; pb[1] = 2'b01;
        run_window(pa, 2, pb, 3, 2, 5, 2, 3, "R9 R10 shared line OR and restart");

        // R8: two groups on separate lines
        settle('0);
        route[0] = 3'd0; route[1] = 3'd5; plen = 4'd4;
        mode[0] = 2'd2; mode[1] = 2'd1;
        @(negedge clk);
        pa = '0; pa[0] = 2'b01;
        pb = pa; pb[1] = 2'b01;
        run_window(pa, 1, pb, 3, 0, 4, 5, 4, "R8 separate lines");

        // R6: programmable bit7 fall with bit3 low
        settle('{2'b00, 2'b10});
        route[0] = 3'd3; plen = 4'd0; mode[0] = 2'd2;
        @(negedge clk);
        run_window('0, -1, '0, 3, 3, 0, NL, 1, "R6 bit7 fall fires width one");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule